// File: doc/BRIEF.md
# Dual H-Bridge Drive Command Decoder

This block turns per-bridge pairs of control inputs into gate-level drive commands for two H-bridges. Each output is commanded high, low or off (high impedance). Bridge A takes two three-level inputs that can be low, high or left floating. Each one arrives already digitised as a two-bit code. Bridge B takes two plain logic inputs. A floating input on bridge A freezes that bridge at its last command. A wake-time sample of bridge A's inputs can also switch the block into a paralleled mode. In that mode bridge B's inputs steer both bridges, so that both bridges can drive one load together.

A run-enable input gates everything. While it is low, all outputs are off. When the block comes out of sleep, the outputs stay off for a programmable wake time. A short drop of run-enable does not count as sleep. Only a drop that lasts the full sleep time resets the held commands and allows the parallel flag to be sampled again. Both delays are given in milliseconds and converted to clock cycles with a clocks-per-millisecond parameter.

Top module: `hbridge_cmd_decoder`

## Requirements
- R1: Output command encoding is 00 = off, 01 = drive low, 10 = drive high; code 11 never appears. An input pair (in1,in2) = (0,0) commands both outputs of the bridge off.
- R2: Pair (0,1) commands output 1 low and output 2 high; pair (1,0) commands output 1 high and output 2 low.
- R3: Pair (1,1) commands both outputs of the bridge low.
- R4: A bridge A input code is 00 = low, 01 = high, 10 or 11 = floating. Outside parallel mode, if either bridge A input floats, bridge A keeps its previous command.
- R5: When both bridge A inputs float at the moment a wake-up begins, the block enters parallel mode. In parallel mode, bridge A takes the same command as bridge B, decoded from bridge B's inputs, and the bridge A input codes have no effect.
- R6: The parallel flag changes only when a wake-up begins from full sleep or after reset. A short run-enable drop keeps the mode unchanged, and a wake-up with valid bridge A inputs clears it.
- R7: On every clock edge that samples run-enable low, all four outputs are off from that edge onward.
- R8: When run-enable is sampled high while the block is asleep, the outputs stay off on that edge and on the next WAKE_MS*CLK_PER_MS edges. The edge after that drives the decoded commands. Drive commands are registered, so outputs follow inputs one edge later.
- R9: If run-enable is low for at most SLEEP_MS*CLK_PER_MS consecutive sampled edges, the block resumes drive one edge after it sees run-enable high again, with no wake delay and with its held commands kept. One more low edge than that puts it to sleep, which clears both bridges' held commands to off.
- R10: Reset puts the block asleep with all outputs off, held commands off and parallel mode cleared. A wake-up that follows reset samples the parallel flag the same way a wake from sleep does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| run_en_i | input | 1 | High to operate, low to request sleep |
| a_in1_code_i | input | 2 | Bridge A input 1 three-level code |
| a_in2_code_i | input | 2 | Bridge A input 2 three-level code |
| b_in1_i | input | 1 | Bridge B input 1 |
| b_in2_i | input | 1 | Bridge B input 2 |
| a_out1_o | output | 2 | Bridge A output 1 drive command |
| a_out2_o | output | 2 | Bridge A output 2 drive command |
| b_out1_o | output | 2 | Bridge B output 1 drive command |
| b_out2_o | output | 2 | Bridge B output 2 drive command |

## Verification
The bench builds the block with CLK_PER_MS = 3, WAKE_MS = 2 and SLEEP_MS = 1. That gives a wake time of 6 cycles and a sleep time of 3 cycles. With these values, the exact edge where drive resumes after a wake can be checked. A run-enable drop can be held for exactly the sleep time and then for one cycle more, which separates a short dip from a real sleep. Because the wake sequences are this short, parallel-mode entry, persistence through a dip and exit through a full sleep all fit in a few hundred cycles.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int NUM_BRIDGES = 2;
    localparam int NUM_TRI     = 2;

    typedef enum logic [1:0] {
        DRV_OFF = 2'b00,
        DRV_LO  = 2'b01,
        DRV_HI  = 2'b10
    } drv_cmd_e;

    typedef enum logic [1:0] {
        PS_SLEEP  = 2'b00,
        PS_WAKING = 2'b01,
        PS_ACTIVE = 2'b10,
        PS_DOZING = 2'b11
    } pwr_state_e;

    typedef struct packed {
        drv_cmd_e out1;
        drv_cmd_e out2;
    } bridge_cmd_t;

    localparam bridge_cmd_t BRIDGE_IDLE = '{out1: DRV_OFF, out2: DRV_OFF};

endpackage

// File: rtl/hbd_tri_level.sv
module hbd_tri_level (
    input  logic [1:0] code_i,
    output logic       level_o,
    output logic       float_o
);
    // codes: 00 low, 01 high, 1x floating
    always_comb begin
        level_o = (code_i == 2'b01);
        float_o = code_i[1];
    end
endmodule

// File: rtl/hbd_pair_decode.sv
module hbd_pair_decode
    import hbd_pkg::*;
(
    input  logic        in1_i,
    input  logic        in2_i,
    output bridge_cmd_t cmd_o
);
    always_comb begin
        unique case ({in1_i, in2_i})
            2'b00:   cmd_o = '{out1: DRV_OFF, out2: DRV_OFF};
            2'b01:   cmd_o = '{out1: DRV_LO,  out2: DRV_HI};
            2'b10:   cmd_o = '{out1: DRV_HI,  out2: DRV_LO};
            default: cmd_o = '{out1: DRV_LO,  out2: DRV_LO};
        endcase
    end
endmodule

// File: rtl/hbd_power_seq.sv
module hbd_power_seq
    import hbd_pkg::*;
#(
    parameter int WAKE_CYC  = 1000,
    parameter int SLEEP_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en_i,
    input  logic a_both_float_i,
    output logic active_o,
    output logic asleep_o,
    output logic par_o
);
    localparam int MAX_CYC = (WAKE_CYC > SLEEP_CYC) ? WAKE_CYC : SLEEP_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] SLEEP_LAST = CNT_W'(SLEEP_CYC - 1);

    typedef struct packed {
        pwr_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             par;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            PS_SLEEP: begin
                if (run_en_i) begin
                    st_d.state = PS_WAKING;
                    st_d.cnt   = '0;
                    st_d.par   = a_both_float_i;
                end
            end
            PS_WAKING: begin
                if (!run_en_i) begin
                    st_d.state = PS_SLEEP;
                end else if (st_q.cnt == WAKE_LAST) begin
                    st_d.state = PS_ACTIVE;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PS_ACTIVE: begin
                if (!run_en_i) begin
                    st_d.state = PS_DOZING;
                    st_d.cnt   = '0;
                end
            end
            default: begin
                if (run_en_i) begin
                    st_d.state = PS_ACTIVE;
                end else if (st_q.cnt == SLEEP_LAST) begin
                    st_d.state = PS_SLEEP;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: PS_SLEEP, cnt: '0, par: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        active_o = (st_q.state == PS_ACTIVE);
        asleep_o = (st_q.state == PS_SLEEP) || (st_q.state == PS_WAKING);
        par_o    = st_q.par;
    end

    // R8
    active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == PS_ACTIVE && $past(st_q.state) != PS_ACTIVE)
        |-> ($past(st_q.state) == PS_WAKING || $past(st_q.state) == PS_DOZING));

    // R8
    wake_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == PS_WAKING && !run_en_i) |=> (st_q.state == PS_SLEEP));

    // R6
    par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.state == PS_SLEEP && run_en_i) |=> $stable(st_q.par));

endmodule

// File: rtl/hbridge_cmd_decoder.sv
module hbridge_cmd_decoder
    import hbd_pkg::*;
#(
    parameter int CLK_PER_MS = 1000,
    parameter int WAKE_MS    = 1,
    parameter int SLEEP_MS   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en_i,
    input  logic [1:0] a_in1_code_i,
    input  logic [1:0] a_in2_code_i,
    input  logic       b_in1_i,
    input  logic       b_in2_i,
    output logic [1:0] a_out1_o,
    output logic [1:0] a_out2_o,
    output logic [1:0] b_out1_o,
    output logic [1:0] b_out2_o
);
    localparam int WAKE_CYC  = CLK_PER_MS * WAKE_MS;
    localparam int SLEEP_CYC = CLK_PER_MS * SLEEP_MS;

    typedef struct packed {
        bridge_cmd_t [NUM_BRIDGES-1:0] cmd;
        bridge_cmd_t [NUM_BRIDGES-1:0] out;
    } drv_t;

    drv_t st_d, st_q;

    logic [1:0]  a_code [NUM_TRI];
    logic        a_lvl  [NUM_TRI];
    logic        a_flt  [NUM_TRI];
    logic        src1   [NUM_BRIDGES];
    logic        src2   [NUM_BRIDGES];
    logic        upd    [NUM_BRIDGES];
    bridge_cmd_t dec    [NUM_BRIDGES];

    logic active_w, asleep_w, par_w, a_both_float, a_any_float;

    always_comb begin
        a_code[0] = a_in1_code_i;
        a_code[1] = a_in2_code_i;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TRI; gi++) begin : g_tri
            hbd_tri_level u_tri (
                .code_i  (a_code[gi]),
                .level_o (a_lvl[gi]),
                .float_o (a_flt[gi])
            );
        end
    endgenerate

    always_comb begin
        a_both_float = a_flt[0] & a_flt[1];
        a_any_float  = a_flt[0] | a_flt[1];
    end

    hbd_power_seq #(
        .WAKE_CYC  (WAKE_CYC),
        .SLEEP_CYC (SLEEP_CYC)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_en_i       (run_en_i),
        .a_both_float_i (a_both_float),
        .active_o       (active_w),
        .asleep_o       (asleep_w),
        .par_o          (par_w)
    );

    // bridge A may be steered by bridge B's pair in parallel mode
    always_comb begin
        src1[0] = par_w ? b_in1_i : a_lvl[0];
        src2[0] = par_w ? b_in2_i : a_lvl[1];
        upd[0]  = par_w | ~a_any_float;
        src1[1] = b_in1_i;
        src2[1] = b_in2_i;
        upd[1]  = 1'b1;
    end

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BRIDGES; gb++) begin : g_br
            hbd_pair_decode u_dec (
                .in1_i (src1[gb]),
                .in2_i (src2[gb]),
                .cmd_o (dec[gb])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NUM_BRIDGES; b++) begin
            if (asleep_w) begin
                st_d.cmd[b] = BRIDGE_IDLE;
            end else if (active_w && run_en_i && upd[b]) begin
                st_d.cmd[b] = dec[b];
            end
            st_d.out[b] = (active_w && run_en_i) ? st_d.cmd[b] : BRIDGE_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cmd: {NUM_BRIDGES{BRIDGE_IDLE}}, out: {NUM_BRIDGES{BRIDGE_IDLE}}};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        a_out1_o = st_q.out[0].out1;
        a_out2_o = st_q.out[0].out2;
        b_out1_o = st_q.out[1].out1;
        b_out2_o = st_q.out[1].out2;
    end

    // R7
    run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |=> (a_out1_o == 2'b00 && a_out2_o == 2'b00 &&
                       b_out1_o == 2'b00 && b_out2_o == 2'b00));

    // R1
    coast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_w && run_en_i && !b_in1_i && !b_in2_i)
        |=> (b_out1_o == 2'b00 && b_out2_o == 2'b00));

    // R2
    forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_w && run_en_i && b_in1_i && !b_in2_i)
        |=> (b_out1_o == 2'b10 && b_out2_o == 2'b01));

    // R3
    brake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_w && run_en_i && b_in1_i && b_in2_i)
        |=> (b_out1_o == 2'b01 && b_out2_o == 2'b01));

    // R1
    no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_out1_o != 2'b11 && a_out2_o != 2'b11 && b_out1_o != 2'b11 && b_out2_o != 2'b11));

    // R5
    par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_w && run_en_i && par_w)
        |=> (a_out1_o == b_out1_o && a_out2_o == b_out2_o));

    // R4
    float_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_w && run_en_i && !par_w && a_any_float && $past(active_w && run_en_i))
        |=> ($stable(a_out1_o) && $stable(a_out2_o)));

endmodule

// File: tb/hbridge_cmd_decoder_bench.sv
module hbridge_cmd_decoder_bench;

    localparam int CPM = 3;
    localparam int WMS = 2;
    localparam int SMS = 1;
    localparam int W   = CPM * WMS;
    localparam int S   = CPM * SMS;

    localparam logic [1:0] OFF = 2'b00;
    localparam logic [1:0] LO  = 2'b01;
    localparam logic [1:0] HI  = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] a1c = 2'b00;
    logic [1:0] a2c = 2'b00;
    logic       b1 = 1'b0;
    logic       b2 = 1'b0;
    logic [1:0] ao1, ao2, bo1, bo2;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    hbridge_cmd_decoder #(
        .CLK_PER_MS (CPM),
        .WAKE_MS    (WMS),
        .SLEEP_MS   (SMS)
    ) u_hbridge_cmd_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en_i     (run_en),
        .a_in1_code_i (a1c),
        .a_in2_code_i (a2c),
        .b_in1_i      (b1),
        .b_in2_i      (b2),
        .a_out1_o     (ao1),
        .a_out2_o     (ao2),
        .b_out1_o     (bo1),
        .b_out2_o     (bo2)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect4(input string tag, input logic [1:0] ea1, input logic [1:0] ea2,
                           input logic [1:0] eb1, input logic [1:0] eb2);
        n_checks++;
        if ({ao1, ao2, bo1, bo2} !== {ea1, ea2, eb1, eb2}) begin
            n_fail++;
            $display("FAIL %s: got A=%b/%b B=%b/%b expected A=%b/%b B=%b/%b",
                     tag, ao1, ao2, bo1, bo2, ea1, ea2, eb1, eb2);
        end
    endtask

    // pair -> expected command for one bridge
    function automatic logic [3:0] pair_cmd(input logic i1, input logic i2);
        case ({i1, i2})
            2'b00:   return {OFF, OFF};
            2'b01:   return {LO, HI};
            2'b10:   return {HI, LO};
            default: return {LO, LO};
        endcase
    endfunction

    // wake from sleep: off on the sampling edge and the next W edges
    task automatic do_wake(input string tag);
        run_en = 1'b1;
        tick(W + 1);
        expect4(tag, OFF, OFF, OFF, OFF);
        tick(1);
    endtask

    // low for S+1 sampled edges: full sleep
    task automatic do_sleep(input string tag);
        run_en = 1'b0;
        tick(1);
        expect4(tag, OFF, OFF, OFF, OFF);
        tick(S);
    endtask

    task automatic t_reset;
        expect4("R10 reset state", OFF, OFF, OFF, OFF);
        tick(2);
        expect4("R10 idle after reset", OFF, OFF, OFF, OFF);
    endtask

    task automatic t_wake;
        a1c = 2'b01; a2c = 2'b00; b1 = 1'b0; b2 = 1'b1;
        do_wake("R8 off during wake");
        expect4("R8 R2 drive after wake", HI, LO, LO, HI);
    endtask

    task automatic t_table;
        for (int p = 0; p < 4; p++) begin
            logic [3:0] e;
            b1 = p[1]; b2 = p[0];
            a1c = {1'b0, p[1]}; a2c = {1'b0, p[0]};
            e = pair_cmd(p[1], p[0]);
            tick(1);
            expect4($sformatf("R1 R2 R3 pair %0d", p), e[3:2], e[1:0], e[3:2], e[1:0]);
        end
    endtask

    task automatic t_float;
        a1c = 2'b01; a2c = 2'b00; b1 = 1'b0; b2 = 1'b0;
        tick(1);
        expect4("R2 A forward", HI, LO, OFF, OFF);
        a1c = 2'b10; a2c = 2'b01;
        tick(1);
        expect4("R4 float code 10 holds", HI, LO, OFF, OFF);
        a1c = 2'b00; a2c = 2'b11;
        tick(1);
        expect4("R4 float code 11 holds", HI, LO, OFF, OFF);
        a1c = 2'b00; a2c = 2'b01;
        tick(1);
        expect4("R4 valid again updates", LO, HI, OFF, OFF);
    endtask

    task automatic t_dip;
        a1c = 2'b01; a2c = 2'b01; b1 = 1'b0; b2 = 1'b0;
        tick(1);
        expect4("R3 A brake", LO, LO, OFF, OFF);
        run_en = 1'b0;
        a1c = 2'b10; a2c = 2'b10;
        tick(1);
        expect4("R7 off at dip", OFF, OFF, OFF, OFF);
        tick(S - 1);
        expect4("R7 off through dip", OFF, OFF, OFF, OFF);
        run_en = 1'b1;
        tick(1);
        expect4("R9 off on return edge", OFF, OFF, OFF, OFF);
        tick(1);
        expect4("R9 held command kept", LO, LO, OFF, OFF);
    endtask

    task automatic t_long;
        a1c = 2'b01; a2c = 2'b00; b1 = 1'b0; b2 = 1'b0;
        tick(1);
        expect4("R2 A forward pre-sleep", HI, LO, OFF, OFF);
        do_sleep("R7 off at sleep");
        a1c = 2'b10; a2c = 2'b00; b1 = 1'b1; b2 = 1'b1;
        do_wake("R8 off during rewake");
        expect4("R9 held cleared by sleep", OFF, OFF, LO, LO);
    endtask

    task automatic t_par;
        do_sleep("R7 off before parallel");
        a1c = 2'b10; a2c = 2'b11; b1 = 1'b1; b2 = 1'b0;
        do_wake("R8 off during parallel wake");
        expect4("R5 parallel forward", HI, LO, HI, LO);
        a1c = 2'b00; a2c = 2'b01; b1 = 1'b0; b2 = 1'b1;
        tick(1);
        expect4("R5 A codes ignored", LO, HI, LO, HI);
        b1 = 1'b1; b2 = 1'b1;
        tick(1);
        expect4("R5 parallel brake", LO, LO, LO, LO);
        run_en = 1'b0; a1c = 2'b00; a2c = 2'b00;
        tick(S);
        run_en = 1'b1; b1 = 1'b1; b2 = 1'b0;
        tick(2);
        expect4("R6 parallel kept over dip", HI, LO, HI, LO);
        do_sleep("R7 off before exit");
        a1c = 2'b01; a2c = 2'b01; b1 = 1'b0; b2 = 1'b0;
        do_wake("R8 off during exit wake");
        expect4("R6 parallel exited", LO, LO, OFF, OFF);
    endtask

    task automatic t_reset_par;
        a1c = 2'b11; a2c = 2'b10; b1 = 1'b0; b2 = 1'b1;
        rst_n = 1'b0;
        tick(1);
        expect4("R10 off in reset", OFF, OFF, OFF, OFF);
        rst_n = 1'b1;
        do_wake("R8 off after reset wake");
        expect4("R10 R5 parallel after reset", LO, HI, LO, HI);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset;
        t_wake;
        t_table;
        t_float;
        t_dip;
        t_long;
        t_par;
        t_reset_par;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run;
    end

endmodule